// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block derives an internal clamp pulse for a video front end. The pulse can be started by a horizontal sync input or by a blanking input, and the sync polarity does not need to be configured. Configuration bits choose the trigger source, the sync edge, the blanking polarity and the pulse width. A bypass mode passes an externally shaped clamp pulse from the sync pin straight to the output.

A second output is a sample strobe for the output black-level sample-and-hold. It is placed a fixed delay after the start of the active blanking interval and always stays inside that interval. When a design has no blanking signal, a fallback bit routes the clamp pulse onto the strobe instead. All inputs pass through two-flop synchronizers. Every timing figure below counts clock cycles from the first rising edge that samples the changed input.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it is released, `clamp_out` and `sample_out` are 0.
- R2: With `cfg_src_blank`=0 and `cfg_lead_edge`=0, a trailing edge of the active sync level starts a pulse. `clamp_out` rises 3 rising clock edges after the edge is first sampled (2 sync stages, then the edge detector and pulse register).
- R3: With `cfg_src_blank`=0 and `cfg_lead_edge`=1, the pulse starts on the leading edge of the active sync level, with the same latency as in R2.
- R4: The sync polarity is detected without configuration. At each rising edge of the synchronized sync, the high and low cycle counts of the line just ended are compared. Sync is taken as active-low when the high count is larger, and active-high otherwise. The polarity is active-high after reset.
- R5: With `cfg_src_blank`=1, the pulse starts on the leading edge of the active blanking level. The active level is high when `cfg_blank_neg`=0 and low when `cfg_blank_neg`=1.
- R6: `cfg_width` codes 0, 1, 2 and 3 give pulses of 8, 16, 24 and 32 clock cycles.
- R7: A trigger that arrives while a pulse is in progress is ignored. The running pulse is neither extended nor restarted.
- R8: With `cfg_bypass`=1, `clamp_out` equals `hsync_in` delayed by exactly 2 clock cycles.
- R9: `sample_out` is high for 8 cycles. It starts when the synchronized blanking has been active for 5 cycles after its leading edge. It is only high while the synchronized blanking is active, and drops as soon as blanking ends.
- R10: With `cfg_no_blank`=1 and the synchronized `blank_in` low, `sample_out` equals `clamp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, or the external clamp pulse in bypass mode |
| blank_in | input | 1 | Blanking input |
| cfg_src_blank | input | 1 | 1: trigger on blanking leading edge; 0: trigger on sync |
| cfg_lead_edge | input | 1 | Sync mode: 1 leading edge, 0 trailing edge |
| cfg_width | input | 2 | Pulse width code, (code+1)*8 cycles |
| cfg_bypass | input | 1 | 1: sync pin drives clamp pulse directly |
| cfg_blank_neg | input | 1 | 1: blanking is active-low |
| cfg_no_blank | input | 1 | 1: clamp pulse feeds sample strobe while blanking is low |
| clamp_out | output | 1 | Internal back-porch clamp pulse |
| sample_out | output | 1 | Output-level sample strobe |

## Verification
A wrong polarity decision shows as clamp pulses that start on the opposite sync edge, within one line of a polarity change. A stuck or misloaded width counter shows on the first pulse as a wrong high-time count on `clamp_out`. A missed busy check shows as a pulse stretched past its programmed width. An error in the strobe position counter shows within one blanking interval, as `sample_out` moving, growing or leaving the window. The bench reference model compares both outputs on every cycle, so each of these errors is flagged on the cycle where it first appears.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef struct packed {
        logic       src_blank;
        logic       lead_edge;
        logic [1:0] width;
        logic       bypass;
        logic       blank_neg;
        logic       no_blank;
    } cpg_cfg_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } sync_edges_t;

    function automatic int unsigned width_cycles(input logic [1:0] code,
                                                 input int unsigned unit);
        return (int'(code) + 1) * unit;
    endfunction

endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cpg_sync_edge.sv
module cpg_sync_edge
    import cpg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hs,
    output sync_edges_t edges,
    output logic        pol_neg
);
    logic             hs_d;
    logic             rise, fall;
    logic [CNT_W-1:0] hi_cnt, lo_cnt;

    assign rise = hs & ~hs_d;
    assign fall = ~hs & hs_d;

    always_comb begin
        edges.lead  = pol_neg ? fall : rise;
        edges.trail = pol_neg ? rise : fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d    <= 1'b0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            pol_neg <= 1'b0;
        end else begin
            hs_d <= hs;
            if (rise) begin
                pol_neg <= (hi_cnt > lo_cnt);
                hi_cnt  <= CNT_W'(1);
                lo_cnt  <= '0;
            end else if (hs) begin
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpg_pulse.sv
module cpg_pulse
    import cpg_pkg::*;
#(
    parameter int WIDTH_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic [1:0] code,
    output logic       active
);
    localparam int MAXW = 4 * WIDTH_UNIT;
    localparam int PW   = $clog2(MAXW + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (trig) begin
            remain <= PW'(width_cycles(code, WIDTH_UNIT));
        end
    end

    assign active = (remain != '0);
endmodule

// File: rtl/cpg_strobe.sv
module cpg_strobe #(
    parameter int OCL_DELAY = 4,
    parameter int OCL_LEN   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_s,
    input  logic blank_neg,
    output logic blank_act,
    output logic blank_lead,
    output logic ocl
);
    localparam int LAST = OCL_DELAY + OCL_LEN;
    localparam int PCW  = $clog2(LAST + 1);

    logic           blank_d;
    logic [PCW-1:0] pos;

    assign blank_act  = blank_s ^ blank_neg;
    assign blank_lead = blank_act & ~(blank_d ^ blank_neg);

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_d <= 1'b0;
            pos     <= '0;
        end else begin
            blank_d <= blank_s;
            if (blank_lead) begin
                pos <= PCW'(1);
            end else if (pos != '0) begin
                if (!blank_act || pos == PCW'(LAST)) pos <= '0;
                else                                   pos <= pos + 1'b1;
            end
        end
    end

    assign ocl = blank_act && (pos > PCW'(OCL_DELAY)) && (pos <= PCW'(LAST));
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import cpg_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WIDTH_UNIT = 8,
    parameter int OCL_DELAY  = 4,
    parameter int OCL_LEN    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       blank_in,
    input  logic       cfg_src_blank,
    input  logic       cfg_lead_edge,
    input  logic [1:0] cfg_width,
    input  logic       cfg_bypass,
    input  logic       cfg_blank_neg,
    input  logic       cfg_no_blank,
    output logic       clamp_out,
    output logic       sample_out
);
    cpg_cfg_t    cfg;
    logic [1:0]  raw_in, sync_q;
    logic        hs_s, bl_s;
    sync_edges_t sedge;
    logic        pol_neg;
    logic        blank_act, blank_lead, ocl;
    logic        trig, pulse_act;

    assign cfg = '{src_blank: cfg_src_blank, lead_edge: cfg_lead_edge,
                   width: cfg_width, bypass: cfg_bypass,
                   blank_neg: cfg_blank_neg, no_blank: cfg_no_blank};

    assign raw_in = {blank_in, hsync_in};

    cpg_sync #(.N(2)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
    );

    assign hs_s = sync_q[0];
    assign bl_s = sync_q[1];

    cpg_sync_edge #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst(rst), .hs(hs_s), .edges(sedge), .pol_neg(pol_neg)
    );

    cpg_strobe #(.OCL_DELAY(OCL_DELAY), .OCL_LEN(OCL_LEN)) u_strobe (
        .clk(clk), .rst(rst), .blank_s(bl_s), .blank_neg(cfg.blank_neg),
        .blank_act(blank_act), .blank_lead(blank_lead), .ocl(ocl)
    );

    always_comb begin
        if (cfg.src_blank)      trig = blank_lead;
        else if (cfg.lead_edge) trig = sedge.lead;
        else                    trig = sedge.trail;
    end

    cpg_pulse #(.WIDTH_UNIT(WIDTH_UNIT)) u_pulse (
        .clk(clk), .rst(rst), .trig(trig), .code(cfg.width), .active(pulse_act)
    );

    assign clamp_out  = cfg.bypass ? hs_s : pulse_act;
    assign sample_out = (cfg.no_blank && !bl_s) ? clamp_out : ocl;

endmodule

// File: rtl/cpg_chk.sv
module cpg_chk #(
    parameter int WIDTH_UNIT = 8,
    parameter int OCL_LEN    = 8
) (
    input logic clk,
    input logic rst,
    input logic hsync_in,
    input logic cfg_bypass,
    input logic cfg_no_blank,
    input logic clamp_out,
    input logic sample_out,
    input logic pulse_act,
    input logic trig,
    input logic blank_act,
    input logic blank_sync,
    input logic ocl
);
    localparam int MAXW = 4 * WIDTH_UNIT;

    logic [1:0] age;
    logic [7:0] prun, orun;

    always_ff @(posedge clk) begin
        if (rst) begin
            age  <= '0;
            prun <= '0;
            orun <= '0;
        end else begin
            if (age != 2'd3) age <= age + 1'b1;
            prun <= pulse_act ? ((prun != 8'hFF) ? prun + 1'b1 : prun) : 8'd0;
            orun <= ocl ? ((orun != 8'hFF) ? orun + 1'b1 : orun) : 8'd0;
        end
    end

    AST_PULSE_FROM_TRIG: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_act) |-> $past(trig)); // R2

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        pulse_act |-> (prun < 8'(MAXW))); // R6

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && age >= 2'd2) |-> (clamp_out == $past(hsync_in, 2))); // R8

    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (sample_out && !(cfg_no_blank && !blank_sync)) |-> blank_act); // R9

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
        ocl |-> (orun < 8'(OCL_LEN))); // R9

    AST_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (cfg_no_blank && !blank_sync) |-> (sample_out == clamp_out)); // R10

endmodule

bind clamp_pulse_gen cpg_chk #(.WIDTH_UNIT(WIDTH_UNIT), .OCL_LEN(OCL_LEN)) u_chk (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .cfg_bypass(cfg_bypass),
    .cfg_no_blank(cfg_no_blank), .clamp_out(clamp_out), .sample_out(sample_out),
    .pulse_act(pulse_act), .trig(trig), .blank_act(blank_act),
    .blank_sync(bl_s), .ocl(ocl)
);

// File: tb/sim_clamp_pulse_gen.sv
module sim_clamp_pulse_gen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic hsync_in = 1'b0, blank_in = 1'b0;
    logic cfg_src_blank = 1'b0, cfg_lead_edge = 1'b0, cfg_bypass = 1'b0;
    logic cfg_blank_neg = 1'b0, cfg_no_blank = 1'b0;
    logic [1:0] cfg_width = 2'd0;
    logic clamp_out, sample_out;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit checking = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clamp_pulse_gen u0 (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .blank_in(blank_in),
        .cfg_src_blank(cfg_src_blank), .cfg_lead_edge(cfg_lead_edge),
        .cfg_width(cfg_width), .cfg_bypass(cfg_bypass),
        .cfg_blank_neg(cfg_blank_neg), .cfg_no_blank(cfg_no_blank),
        .clamp_out(clamp_out), .sample_out(sample_out)
    );

    // behavioural reference: input history, line timing, pulse and strobe timers
    bit h_hist[3];   // [0] newest sample, [1] synchronized, [2] previous synchronized
    bit b_hist[3];
    int hi_time, lo_time, remain_t, win_pos;
    bit sync_neg;

    always @(posedge clk) begin
        bit up, down, lead, trail, bact, blead, fire;
        if (rst) begin
            h_hist = '{0, 0, 0}; b_hist = '{0, 0, 0};
            hi_time = 0; lo_time = 0; remain_t = 0; win_pos = 0; sync_neg = 0;
        end else begin
            up    = h_hist[1] && !h_hist[2];
            down  = !h_hist[1] && h_hist[2];
            lead  = sync_neg ? down : up;
            trail = sync_neg ? up : down;
            bact  = b_hist[1] ^ cfg_blank_neg;
            blead = bact && !(b_hist[2] ^ cfg_blank_neg);
            fire  = cfg_src_blank ? blead : (cfg_lead_edge ? lead : trail);
            if (remain_t > 0) remain_t--;
            else if (fire) remain_t = 8 * (int'(cfg_width) + 1);
            if (up) begin
                sync_neg = hi_time > lo_time; hi_time = 1; lo_time = 0;
            end else if (h_hist[1]) hi_time++;
            else lo_time++;
            if (blead) win_pos = 1;
            else if (win_pos > 0) win_pos = (!bact || win_pos == 12) ? 0 : win_pos + 1;
            h_hist[2] = h_hist[1]; h_hist[1] = h_hist[0]; h_hist[0] = hsync_in;
            b_hist[2] = b_hist[1]; b_hist[1] = b_hist[0]; b_hist[0] = blank_in;
        end
    end

    always @(negedge clk) begin
        bit exp_c, exp_s, ocl_e;
        if (checking) begin
            exp_c = cfg_bypass ? h_hist[1] : (remain_t > 0);
            ocl_e = (b_hist[1] ^ cfg_blank_neg) && win_pos > 4 && win_pos <= 12;
            exp_s = (cfg_no_blank && !b_hist[1]) ? exp_c : ocl_e;
            checks++;
            if (clamp_out !== exp_c) begin
                fails++;
                $display("FAIL %s clamp_out got %b exp %b at %0t", phase, clamp_out, exp_c, $time);
            end
            checks++;
            if (sample_out !== exp_s) begin
                fails++;
                $display("FAIL %s sample_out got %b exp %b at %0t", phase, sample_out, exp_s, $time);
            end
        end
    end

    task automatic run_lines(input int n, input int period, input int hlen, input int blen);
        for (int l = 0; l < n; l++) begin
            for (int i = 0; i < period; i++) begin
                @(negedge clk); #1;
                hsync_in = (i < hlen);
                blank_in = (i < blen) ^ cfg_blank_neg;
            end
        end
    endtask

    task automatic set_cfg(input bit sb, input bit le, input int w, input bit bp,
                           input bit bn, input bit nb);
        @(negedge clk); #1;
        cfg_src_blank = sb; cfg_lead_edge = le; cfg_width = 2'(w);
        cfg_bypass = bp; cfg_blank_neg = bn; cfg_no_blank = nb;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (clamp_out !== 1'b0 || sample_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs got %b%b exp 00", clamp_out, sample_out);
        end
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (clamp_out !== 1'b0 || sample_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release got %b%b exp 00", clamp_out, sample_out);
        end
        checking = 1'b1;

        phase = "R2"; set_cfg(0, 0, 0, 0, 0, 0); run_lines(4, 100, 10, 0);
        phase = "R6"; for (int w = 1; w < 4; w++) begin
            set_cfg(0, 0, w, 0, 0, 0); run_lines(2, 100, 10, 0);
        end
        phase = "R3"; set_cfg(0, 1, 1, 0, 0, 0); run_lines(3, 100, 10, 0);
        phase = "R4"; set_cfg(0, 1, 0, 0, 0, 0); run_lines(4, 100, 90, 0);
        set_cfg(0, 0, 2, 0, 0, 0); run_lines(3, 100, 85, 0);
        set_cfg(0, 0, 0, 0, 0, 0); run_lines(3, 100, 12, 0);
        phase = "R7"; set_cfg(0, 0, 3, 0, 0, 0); run_lines(6, 20, 5, 0);
        set_cfg(0, 1, 3, 0, 0, 0); run_lines(5, 14, 4, 0);
        phase = "R5"; set_cfg(1, 0, 1, 0, 0, 0); run_lines(3, 120, 10, 30);
        set_cfg(1, 0, 0, 0, 1, 0); run_lines(3, 120, 10, 30);
        phase = "R9"; set_cfg(1, 0, 0, 0, 0, 0); run_lines(3, 60, 10, 7);
        set_cfg(1, 0, 0, 0, 1, 0); run_lines(3, 60, 10, 9);
        phase = "R8"; set_cfg(0, 0, 0, 1, 0, 0); run_lines(3, 37, 6, 10);
        run_lines(4, 11, 3, 0);
        phase = "R10"; set_cfg(0, 0, 1, 0, 0, 1); run_lines(4, 100, 10, 0);
        set_cfg(0, 1, 0, 0, 0, 1); run_lines(2, 100, 10, 30);
        repeat (4) @(negedge clk);
        checking = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule